// File: doc/BRIEF.md
# Two-Wire Register Slave Front End

This block lets an external host reach the byte-wide register file of a measurement device over a two-wire serial bus of up to 400 kHz. It oversamples the clock and data lines with the fast system clock, cleans them through synchronizers and a short-pulse filter, and finds the START, repeated START and STOP conditions. It answers only to one fixed 7-bit device address. A write transfer sets an internal byte pointer and then writes data at that pointer, advancing it after each byte. A read transfer sets the pointer with a short write, turns the bus round with a repeated START and streams bytes back until the host ends it with a NAK.

The register file sits outside the block. The block drives a read address. It gets back the aligned pair of bytes that holds that address, and it issues one-cycle write strobes. It protects the register file in four ways. It drops writes to addresses that cannot be written. It drops writes reached by auto-increment above the low register window. It gives the power-on flag of the status register clear-only behaviour. It freezes the low half of a 16-bit register once the host has read its high half. A separate timer raises a sleep request when both bus lines stay low for a long time, if the device allows sleeping.

Top module: `twi_reg_slave`

## Requirements
- R1: After a START, the block pulls SDA low on the ninth clock only when the seven address bits equal 0110110. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: In a write transfer, the first byte after the address (bit 0 = 0) loads the byte pointer. Each later complete byte is acknowledged and gives at most one `wr_en` pulse, with `wr_addr` set to the pointer. The pointer then advances by one.
- R3: Only addresses 01h, 10h, 11h, 61h and 62h accept writes. A byte aimed at any other address is acknowledged but produces no write strobe.
- R4: A data byte whose address was reached by auto-increment and is above 4Fh is discarded. The first data byte after the pointer byte is written whenever R3 allows it.
- R5: In a read transfer, after a repeated START with bit 0 = 1, bytes are sent msb first starting at the stored pointer. The pointer advances after each byte. An acknowledge from the host fetches the next byte. A NAK makes the block release SDA and wait for a new START.
- R6: Reading an even address from 08h to 10h latches the odd partner byte at that moment. A later read of the partner in the same transfer returns the latched value even if the register changed. A new START or a STOP drops the latch.
- R7: Once the pointer has passed FFh, every further byte read is FFh.
- R8: A write to 01h takes bits 5:3 from the data. It keeps bits 7, 2, 1 and 0 at their current values. It sets bit 6 to the current bit 6 AND the written bit 6, so the flag can be cleared but never set.
- R9: A START or STOP that arrives before all eight bits of a data byte are in discards that byte with no write strobe. The bus state starts over.
- R10: With `sleep_en` high, `sleep_req` rises once both lines have been low without a break for about `SLEEP_PRESCALE*SLEEP_TICKS` cycles. It falls within a few cycles of either line going high or `sleep_en` going low. Any high level restarts the count.
- R11: A pulse shorter than `FILT_HOLD` system clocks on SCL or SDA is ignored, so it neither clocks a bit nor looks like a START or STOP.
- R12: The block changes its SDA drive only while SCL is low, outside START and STOP conditions. It releases SDA at the end of every acknowledge clock it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | High pulls the data line low (open-drain enable) |
| rd_addr | output | 8 | Address of the byte the block may fetch next |
| rd_pair | input | 16 | Bytes at {rd_addr with bit 0 cleared, rd_addr with bit 0 set}, high byte first |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 8 | Register address for the write strobe |
| wr_data | output | 8 | Byte to store, status merge already applied |
| sleep_en | input | 1 | Sleep permitted (status register enable bit) |
| sleep_req | output | 1 | Bus held low long enough, enter low-power mode |

## Verification
The bench sweeps all 128 device addresses. A loose compare would acknowledge a near-miss, and a stuck compare would block every transfer. It writes single bytes across the whole writable, read-only and reserved range and in bursts that cross 4Fh. Writes leaking into protected cells, or a first-byte rule that is missing, would show up as register mismatches. It changes the low half of a 16-bit register during the read of its high half, alongside a control pair outside the latched range. Without the snapshot the changed byte would come back; with a latch that is too broad, the control would come back stale. It also reads across FFh, aborts bytes partway with STOP and START, injects one-cycle glitches, and holds the lines low for times below and above the sleep limit. A broken filter would gain bits, a leaky abort would commit partial bytes, and a badly reset timer would sleep on broken-up low stretches.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } bus_state_t;

    typedef enum logic [1:0] {
        K_SADDR,
        K_MADDR,
        K_WDATA
    } rx_kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam logic [6:0] DEV_ADDR    = 7'b0110110;
    localparam logic [7:0] STATUS_ADDR = 8'h01;
    localparam logic [7:0] INC_LIMIT   = 8'h4F;
    localparam logic [7:0] PAIR_FIRST  = 8'h08;
    localparam logic [7:0] PAIR_LAST   = 8'h11;
    localparam logic [7:0] KEEP_MASK   = 8'h87;
    localparam logic [7:0] LOAD_MASK   = 8'h38;
    localparam int         FLAG_BIT    = 6;

    function automatic logic is_writable(input logic [7:0] a);
        return (a == STATUS_ADDR) || (a == 8'h10) || (a == 8'h11) ||
               (a == 8'h61) || (a == 8'h62);
    endfunction

    function automatic logic is_pair_high(input logic [7:0] a);
        return (a >= PAIR_FIRST) && (a <= PAIR_LAST) && !a[0];
    endfunction

    function automatic logic [7:0] merge_status(input logic [7:0] cur,
                                                input logic [7:0] nw);
        logic [7:0] r;
        r = (cur & KEEP_MASK) | (nw & LOAD_MASK);
        r[FLAG_BIT] = cur[FLAG_BIT] & nw[FLAG_BIT];
        return r;
    endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_HOLD   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(FILT_HOLD + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;
    logic                   synced;

    assign synced   = sync_q[SYNC_STAGES-1];
    assign line_out = level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            if (synced == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_HOLD - 1)) begin
                level_q <= synced;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
    import twi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.start = scl_q && scl && sda_q && !sda;
        evt.stop  = scl_q && scl && !sda_q && sda;
        evt.rise  = !scl_q && scl;
        evt.fall  = scl_q && !scl;
    end
endmodule

// File: rtl/twi_sleep_timer.sv
module twi_sleep_timer #(
    parameter int SLEEP_PRESCALE = 50000,
    parameter int SLEEP_TICKS    = 1800
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    input  logic enable,
    output logic sleep_req
);
    localparam int PW = $clog2(SLEEP_PRESCALE);
    localparam int TW = $clog2(SLEEP_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic          req_q;
    logic          both_low;

    assign both_low  = !scl && !sda;
    assign sleep_req = req_q;

    always_ff @(posedge clk) begin
        if (rst || !both_low || !enable) begin
            pre_q  <= '0;
            tick_q <= '0;
            req_q  <= 1'b0;
        end else if (!req_q) begin
            if (pre_q == PW'(SLEEP_PRESCALE - 1)) begin
                pre_q <= '0;
                if (tick_q == TW'(SLEEP_TICKS - 1)) begin
                    req_q <= 1'b1;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FILT_HOLD      = 3,
    parameter int SLEEP_PRESCALE = 50000,
    parameter int SLEEP_TICKS    = 1800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    output logic [7:0]  rd_addr,
    input  logic [15:0] rd_pair,
    output logic        wr_en,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    input  logic        sleep_en,
    output logic        sleep_req
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;
    bus_evt_t          ev;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        twi_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_HOLD  (FILT_HOLD)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .line_in (raw_lines[g]),
            .line_out(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    twi_cond_detect u_det (
        .clk(clk),
        .rst(rst),
        .scl(scl_f),
        .sda(sda_f),
        .evt(ev)
    );

    twi_sleep_timer #(
        .SLEEP_PRESCALE(SLEEP_PRESCALE),
        .SLEEP_TICKS   (SLEEP_TICKS)
    ) u_sleep (
        .clk      (clk),
        .rst      (rst),
        .scl      (scl_f),
        .sda      (sda_f),
        .enable   (sleep_en),
        .sleep_req(sleep_req)
    );

    bus_state_t state_q;
    rx_kind_t   kind_q;
    logic [3:0] bit_cnt_q;
    logic [7:0] shreg_q, txreg_q;
    logic [8:0] ptr_q;
    logic       first_q, rw_q, mack_q, oe_q;
    logic       snap_v_q;
    logic [7:0] snap_a_q, snap_b_q;
    logic       wr_en_q;
    logic [7:0] wr_addr_q, wr_data_q;

    logic [7:0] fetch_byte;
    logic       fetch_snap;
    logic       wr_ok;
    logic [7:0] wr_val;
    logic [8:0] ptr_next;

    assign rd_addr = ptr_q[7:0];
    assign sda_oe  = oe_q;
    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;

    always_comb begin
        if (ptr_q[8]) begin
            fetch_byte = 8'hFF;
        end else if (snap_v_q && (snap_a_q == ptr_q[7:0])) begin
            fetch_byte = snap_b_q;
        end else if (ptr_q[0]) begin
            fetch_byte = rd_pair[7:0];
        end else begin
            fetch_byte = rd_pair[15:8];
        end
        fetch_snap = !ptr_q[8] && is_pair_high(ptr_q[7:0]);
        wr_ok = !ptr_q[8] && is_writable(ptr_q[7:0]) &&
                (first_q || (ptr_q[7:0] <= INC_LIMIT));
        wr_val = (ptr_q[7:0] == STATUS_ADDR) ?
                 merge_status(rd_pair[7:0], shreg_q) : shreg_q;
        ptr_next = ptr_q[8] ? ptr_q : ptr_q + 9'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            kind_q    <= K_SADDR;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            txreg_q   <= '0;
            ptr_q     <= '0;
            first_q   <= 1'b0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            snap_v_q  <= 1'b0;
            snap_a_q  <= '0;
            snap_b_q  <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (ev.start) begin
                state_q   <= ST_RX;
                kind_q    <= K_SADDR;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
                snap_v_q  <= 1'b0;
            end else if (ev.stop) begin
                state_q  <= ST_IDLE;
                oe_q     <= 1'b0;
                snap_v_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        oe_q <= 1'b0;
                    end
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg_q   <= {shreg_q[6:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (ev.fall && (bit_cnt_q == 4'd8)) begin
                            bit_cnt_q <= '0;
                            unique case (kind_q)
                                K_SADDR: begin
                                    if (shreg_q[7:1] == DEV_ADDR) begin
                                        rw_q    <= shreg_q[0];
                                        oe_q    <= 1'b1;
                                        state_q <= ST_RXACK;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                K_MADDR: begin
                                    ptr_q   <= {1'b0, shreg_q};
                                    first_q <= 1'b1;
                                    oe_q    <= 1'b1;
                                    state_q <= ST_RXACK;
                                end
                                default: begin
                                    if (wr_ok) begin
                                        wr_en_q   <= 1'b1;
                                        wr_addr_q <= ptr_q[7:0];
                                        wr_data_q <= wr_val;
                                    end
                                    ptr_q   <= ptr_next;
                                    first_q <= 1'b0;
                                    oe_q    <= 1'b1;
                                    state_q <= ST_RXACK;
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (ev.fall) begin
                            if ((kind_q == K_SADDR) && rw_q) begin
                                txreg_q   <= fetch_byte;
                                oe_q      <= ~fetch_byte[7];
                                bit_cnt_q <= '0;
                                state_q   <= ST_TX;
                                if (fetch_snap) begin
                                    snap_v_q <= 1'b1;
                                    snap_a_q <= ptr_q[7:0] | 8'h01;
                                    snap_b_q <= rd_pair[7:0];
                                end
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_RX;
                                kind_q  <= (kind_q == K_SADDR) ? K_MADDR : K_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (ev.fall) begin
                            if (bit_cnt_q == 4'd8) begin
                                oe_q    <= 1'b0;
                                ptr_q   <= ptr_next;
                                state_q <= ST_TXACK;
                            end else begin
                                txreg_q <= {txreg_q[6:0], 1'b0};
                                oe_q    <= ~txreg_q[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev.rise) begin
                            mack_q <= !sda_f;
                        end else if (ev.fall) begin
                            if (mack_q) begin
                                txreg_q   <= fetch_byte;
                                oe_q      <= ~fetch_byte[7];
                                bit_cnt_q <= '0;
                                state_q   <= ST_TX;
                                if (fetch_snap) begin
                                    snap_v_q <= 1'b1;
                                    snap_a_q <= ptr_q[7:0] | 8'h01;
                                    snap_b_q <= rd_pair[7:0];
                                end
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
    import twi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       sda_f,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       sleep_en,
    input logic       sleep_req
);
    AST_OE_SCL_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f) && !ev_start && !ev_stop) |-> $stable(sda_oe)); // R12

    AST_WR_LEGAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> is_writable(wr_addr)); // R3

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R2

    AST_WAKE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_f || sda_f) |=> !sleep_req); // R10

    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (rst)
        !sleep_en |=> !sleep_req); // R10

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |=> !sda_oe); // R9
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sleep_en (sleep_en),
    .sleep_req(sleep_req)
);

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;
    localparam int Q = 6;
    localparam int PRE = 4;
    localparam int TICKS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, wr_en, sleep_req;
    logic sleep_en = 1'b0;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [15:0] rd_pair;
    logic sda_line;
    logic g_scl = 1'b0;
    logic g_sda = 1'b0;

    logic [7:0] regs [256];
    logic [7:0] expv [256];
    int n_vec = 0;
    int n_fail = 0;
    int wr_count = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign rd_pair = {regs[{rd_addr[7:1], 1'b0}], regs[{rd_addr[7:1], 1'b1}]};

    twi_reg_slave #(
        .SYNC_STAGES(2), .FILT_HOLD(2),
        .SLEEP_PRESCALE(PRE), .SLEEP_TICKS(TICKS)
    ) uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_pair(rd_pair),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sleep_en(sleep_en), .sleep_req(sleep_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) begin
            regs[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wc(Q);
        m_scl = 1'b1; wc(Q);
        m_sda = 1'b0; wc(Q);
        m_scl = 1'b0; wc(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wc(Q);
        m_scl = 1'b1; wc(Q);
        m_sda = 1'b1; wc(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda = b; wc(Q);
        m_scl = 1'b1; wc(2);
        if (g_scl) begin m_scl = 1'b0; wc(1); m_scl = 1'b1; end
        if (g_sda) begin m_sda = ~m_sda; wc(1); m_sda = ~m_sda; end
        wc(Q - 2);
        r = sda_line; wc(Q);
        m_scl = 1'b0; wc(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_bits(output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            d = {d[6:0], r};
        end
    endtask

    task automatic exp_write(input logic [7:0] a, input logic [7:0] d, input logic first);
        logic ok;
        logic [7:0] nv;
        ok = (a == 8'h01) || (a == 8'h10) || (a == 8'h11) || (a == 8'h61) || (a == 8'h62);
        if (!first && a > 8'h4F) ok = 1'b0;
        if (ok) begin
            if (a == 8'h01) begin
                nv = (expv[1] & 8'h87) | (d & 8'h38);
                nv[6] = expv[1][6] & d[6];
            end else begin
                nv = d;
            end
            expv[a] = nv;
        end
    endtask

    task automatic wr_txn(input logic [7:0] ma, input int n, input logic [7:0] seed, input string req);
        logic ack;
        logic [7:0] d;
        bus_start;
        send_byte(8'h6C, ack); chk({req, " addr ack"}, ack, 1'b1);
        send_byte(ma, ack);    chk({req, " ptr ack"}, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            d = seed + 8'(i * 29);
            send_byte(d, ack);
            chk({req, " data ack"}, ack, 1'b1);
            exp_write(ma + 8'(i), d, i == 0);
        end
        bus_stop;
        wc(4);
        for (int i = 0; i < n; i++)
            chk({req, " reg"}, regs[ma + 8'(i)], expv[ma + 8'(i)]);
    endtask

    logic [7:0] rbuf [8];

    task automatic rd_txn(input logic [7:0] ma, input int n, input logic poke,
                          input logic [7:0] pa, input logic [7:0] pv);
        logic ack, r;
        logic [7:0] d;
        bus_start;
        send_byte(8'h6C, ack); chk("R5 addr-w ack", ack, 1'b1);
        send_byte(ma, ack);    chk("R5 ptr ack", ack, 1'b1);
        bus_start;
        send_byte(8'h6D, ack); chk("R5 addr-r ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_bits(d);
            rbuf[i] = d;
            if (poke && i == 0) begin regs[pa] = pv; expv[pa] = pv; end
            clk_bit((i == n - 1) ? 1'b1 : 1'b0, r);
        end
        bus_stop;
        wc(4);
    endtask

    initial begin
        logic ack, r;
        int wc0;
        logic [7:0] old;
        for (int i = 0; i < 256; i++) begin
            regs[i] = 8'(i * 7 + 3);
            expv[i] = 8'(i * 7 + 3);
        end
        regs[1] = 8'h73; expv[1] = 8'h73;
        wc(5);
        chk("R12 reset oe", sda_oe, 1'b0);
        chk("R2 reset wr_en", wr_en, 1'b0);
        chk("R10 reset sleep", sleep_req, 1'b0);
        rst = 1'b0;
        wc(5);

        // R1: sweep every 7-bit address
        for (int a = 0; a < 128; a++) begin
            bus_start;
            send_byte({7'(a), 1'b0}, ack);
            chk("R1 address ack", ack, (a == 8'h36));
            chk("R12 released after ack", sda_oe, 1'b0);
            bus_stop;
        end
        chk("R1 no stray writes", wr_count, 0);

        // R2/R3/R8 single-byte writes across the map
        for (int a = 0; a < 20; a++) wr_txn(8'(a), 1, 8'(a) ^ 8'hA5, "R3 single");
        for (int a = 8'h4E; a <= 8'h51; a++) wr_txn(8'(a), 1, 8'h5C, "R3 reserved");
        for (int a = 8'h5F; a <= 8'h65; a++) wr_txn(8'(a), 1, 8'(a) ^ 8'h3C, "R3 upper");
        wr_txn(8'hFE, 2, 8'h11, "R3 top");

        // R8 flag clear-only, read-only low bits kept
        regs[1] = 8'h73; expv[1] = 8'h73;
        wr_txn(8'h01, 1, 8'h00, "R8 clear");
        chk("R8 flag cleared", regs[1], 8'h03);
        wr_txn(8'h01, 1, 8'hFC, "R8 set try");
        chk("R8 flag stays clear", regs[1], 8'h3B);

        // R2/R4 bursts
        wr_txn(8'h0F, 4, 8'h21, "R2 burst low");
        wr_txn(8'h4E, 4, 8'h42, "R4 burst mid");
        wc0 = wr_count;
        wr_txn(8'h61, 3, 8'h90, "R4 burst high");
        chk("R4 only first byte written", wr_count - wc0, 1);
        wr_txn(8'h62, 1, 8'h17, "R4 direct");

        // R5 reads with auto-increment
        for (int s = 0; s < 6; s++) begin
            logic [7:0] st;
            st = (s == 0) ? 8'h00 : (s == 1) ? 8'h08 : (s == 2) ? 8'h0B :
                 (s == 3) ? 8'h5F : (s == 4) ? 8'h10 : 8'h61;
            rd_txn(st, 4, 1'b0, 8'h00, 8'h00);
            for (int i = 0; i < 4; i++) chk("R5 read data", rbuf[i], expv[st + 8'(i)]);
        end

        // R7 past the top
        rd_txn(8'hFD, 6, 1'b0, 8'h00, 8'h00);
        chk("R7 FD", rbuf[0], expv[8'hFD]);
        chk("R7 FE", rbuf[1], expv[8'hFE]);
        chk("R7 FF", rbuf[2], expv[8'hFF]);
        for (int i = 3; i < 6; i++) chk("R7 beyond", rbuf[i], 8'hFF);

        // R6 snapshot versus live control
        old = regs[8'h0F];
        rd_txn(8'h0E, 2, 1'b1, 8'h0F, old ^ 8'hFF);
        chk("R6 snapshot low byte", rbuf[1], old);
        old = regs[8'h11];
        rd_txn(8'h10, 2, 1'b1, 8'h11, old + 8'h55);
        chk("R6 snapshot acr", rbuf[1], old);
        rd_txn(8'h04, 2, 1'b1, 8'h05, 8'hC3);
        chk("R6 live outside range", rbuf[1], 8'hC3);
        rd_txn(8'h0F, 1, 1'b0, 8'h00, 8'h00);
        chk("R6 latch dropped", rbuf[0], expv[8'h0F]);

        // R9 mid-byte abort by STOP and START
        wc0 = wr_count;
        bus_start;
        send_byte(8'h6C, ack); send_byte(8'h62, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
        bus_stop;
        wc(4);
        chk("R9 stop abort", wr_count - wc0, 0);
        bus_start;
        send_byte(8'h6C, ack); send_byte(8'h61, ack);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, r);
        bus_start;
        send_byte(8'h6C, ack);
        chk("R9 restart acks", ack, 1'b1);
        send_byte(8'h00, ack);
        bus_stop;
        wc(4);
        chk("R9 start abort", wr_count - wc0, 0);
        chk("R9 reg 61 kept", regs[8'h61], expv[8'h61]);

        // R11 glitches on each line
        g_scl = 1'b1;
        wr_txn(8'h10, 1, 8'h3C, "R11 scl glitch");
        g_scl = 1'b0;
        g_sda = 1'b1;
        wr_txn(8'h11, 1, 8'hA6, "R11 sda glitch");
        g_sda = 1'b0;

        for (int a = 0; a < 256; a++) chk("R3 final map", regs[a], expv[a]);

        // R10 sleep request
        sleep_en = 1'b1;
        m_sda = 1'b0; wc(Q);
        m_scl = 1'b0; wc(16);
        chk("R10 not yet", sleep_req, 1'b0);
        wc(44);
        chk("R10 asserted", sleep_req, 1'b1);
        m_sda = 1'b1; wc(10);
        chk("R10 wake", sleep_req, 1'b0);
        m_sda = 1'b0; wc(24);
        m_sda = 1'b1; wc(6);
        m_sda = 1'b0; wc(24);
        chk("R10 count restarts", sleep_req, 1'b0);
        wc(40);
        chk("R10 asserted again", sleep_req, 1'b1);
        sleep_en = 1'b0; wc(3);
        chk("R10 disabled clears", sleep_req, 1'b0);
        wc(100);
        chk("R10 disabled never", sleep_req, 1'b0);
        m_scl = 1'b1; wc(Q);
        m_sda = 1'b1; wc(Q);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule